// File: doc/BRIEF.md
# Dual-Write Dual-Read Lane-Masked Memory

This block is a 512-entry store of 18-bit words that serves four independent accesses every clock. Two write ports and two read ports all act in the same cycle. Each word is split into two 9-bit lanes. Every write port carries one enable per lane, so a write can touch the low lane, the high lane, or both. Reads are synchronous. The word comes back one cycle after the request, flagged by a response valid.

When both write ports hit the same address in the same cycle and their lane enables overlap, a mode pin selects how the clash is settled.

- **Priority mode:** port A wins outright. The whole of port B's write is discarded, and port B sees a one-cycle collision pulse.
- **Lane-wise mode:** the clash is settled lane by lane, and port B's data lands in every lane both ports enable. No pulse is raised.

Writes whose lane enables do not overlap always merge into the one word, in either mode.

Every data path is a request qualified by a valid. The block accepts a request in every cycle, so there is no ready signal and no back-pressure. A read response is presented for exactly one cycle and cannot be stalled. The collision pulse and the mode pin are plain control signals.

Top module: `qpram_quad`

## Requirements
- R1: While reset is asserted (rst_n low), and in the first cycle after it is released, `ra_rvalid`, `rb_rvalid` and `wb_collide` are low.
- R2: A write changes only the lanes whose enable bit is set. Lane enable bit 0 covers data bits 8:0 and bit 1 covers bits 17:9. The other lane of the stored word keeps its old value.
- R3: A read request accepted at a clock edge gives `*_rvalid` high and the stored word on `*_rdata` after the next edge, for exactly one cycle. Both read ports work independently in the same cycle.
- R4: A read of an address that is being written in the same cycle returns the word as it was before that write.
- R5: With `arb_mode` = 1, two valid writes to one address with overlapping lane enables store only port A's lanes. All of port B's lanes are dropped, and `wb_collide` is high for the one cycle after that edge.
- R6: With `arb_mode` = 0, two valid writes to one address with overlapping lanes store port B's data in the shared lanes and each port's data in the lanes only it enables. `wb_collide` stays low.
- R7: Two valid writes to one address whose lane enables do not overlap both take effect, merged into one word, in either mode. `wb_collide` stays low.
- R8: Valid writes from the two ports to different addresses in the same cycle both take effect.
- R9: A write with valid low, or with both lane enables low, leaves memory unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the control state |
| arb_mode | input | 1 | 1 = port A has priority on a clash, 0 = lane-wise merge with B winning shared lanes |
| wa_valid | input | 1 | Port A write request valid |
| wa_addr | input | 9 | Port A write address |
| wa_lane_en | input | 2 | Port A lane enables (bit 0 = bits 8:0, bit 1 = bits 17:9) |
| wa_data | input | 18 | Port A write data |
| wb_valid | input | 1 | Port B write request valid |
| wb_addr | input | 9 | Port B write address |
| wb_lane_en | input | 2 | Port B lane enables |
| wb_data | input | 18 | Port B write data |
| wb_collide | output | 1 | One-cycle pulse: port B's write was dropped by priority arbitration |
| ra_valid | input | 1 | Read port A request valid |
| ra_addr | input | 9 | Read port A address |
| ra_rvalid | output | 1 | Read port A response valid |
| ra_rdata | output | 18 | Read port A response data |
| rb_valid | input | 1 | Read port B request valid |
| rb_addr | input | 9 | Read port B address |
| rb_rvalid | output | 1 | Read port B response valid |
| rb_rdata | output | 18 | Read port B response data |

## Verification
The bench builds the block with its default parameters: 9-bit addresses and two 9-bit lanes. At that size, every lane-enable combination for both ports can be driven against one address in both arbitration modes, including partial overlaps and disjoint lanes. A reference word array is updated from the requirements alone. Each read response and each cycle of the collision pulse is compared against that array. Reads issued in the same cycle as a write to the same address show the read-before-write ordering.

// File: rtl/qpram_pkg.sv
package qpram_pkg;
  localparam int QP_ADDR_W = 9;
  localparam int QP_LANE_W = 9;
  localparam int QP_LANES  = 2;

  typedef enum logic {
    ARB_LANEWISE = 1'b0,
    ARB_A_WINS   = 1'b1
  } arb_mode_e;
endpackage

// File: rtl/qpram_wr_resolve.sv
module qpram_wr_resolve
  import qpram_pkg::*;
#(
  parameter int ADDR_W = QP_ADDR_W,
  parameter int LANES  = QP_LANES
) (
  input  arb_mode_e         mode,
  input  logic              a_valid,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [LANES-1:0]  a_lanes,
  input  logic              b_valid,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [LANES-1:0]  b_lanes,
  output logic [LANES-1:0]  a_we,
  output logic [LANES-1:0]  b_we,
  output logic              clash
);
  logic             same_word;
  logic [LANES-1:0] a_act, b_act, shared;

  always_comb begin
    same_word = a_valid && b_valid && (a_addr == b_addr);
    a_act     = a_valid ? a_lanes : '0;
    b_act     = b_valid ? b_lanes : '0;
    shared    = same_word ? (a_act & b_act) : '0;
    clash     = 1'b0;
    a_we      = a_act;
    b_we      = b_act;
    if (|shared) begin
      if (mode == ARB_A_WINS) begin
        clash = 1'b1;
        b_we  = '0;
      end else begin
        a_we  = a_act & ~shared;
      end
    end
  end
endmodule

// File: rtl/qpram_store.sv
module qpram_store
  import qpram_pkg::*;
#(
  parameter int ADDR_W = QP_ADDR_W,
  parameter int LANE_W = QP_LANE_W,
  parameter int LANES  = QP_LANES
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [LANES-1:0]         a_we,
  input  logic [ADDR_W-1:0]        a_addr,
  input  logic [LANES*LANE_W-1:0]  a_data,
  input  logic [LANES-1:0]         b_we,
  input  logic [ADDR_W-1:0]        b_addr,
  input  logic [LANES*LANE_W-1:0]  b_data,
  input  logic                     x_en,
  input  logic [ADDR_W-1:0]        x_addr,
  output logic [LANES*LANE_W-1:0]  x_q,
  input  logic                     y_en,
  input  logic [ADDR_W-1:0]        y_addr,
  output logic [LANES*LANE_W-1:0]  y_q
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] bank [DEPTH];
    logic [LANE_W-1:0] x_lane, y_lane;

    always_ff @(posedge clk) begin
      if (a_we[g]) bank[a_addr] <= a_data[g*LANE_W +: LANE_W];
      if (b_we[g]) bank[b_addr] <= b_data[g*LANE_W +: LANE_W];
      if (x_en)    x_lane <= bank[x_addr];
      if (y_en)    y_lane <= bank[y_addr];
    end

    assign x_q[g*LANE_W +: LANE_W] = x_lane;
    assign y_q[g*LANE_W +: LANE_W] = y_lane;

    // R6: the resolver never hands one lane of one word to both writers
    a_r6_single_lane_writer: assert property (@(posedge clk) disable iff (!rst_n)
      !(a_we[g] && b_we[g] && (a_addr == b_addr)));
  end
endmodule

// File: rtl/qpram_rd_port.sv
module qpram_rd_port (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  output logic rsp
);
  always_ff @(posedge clk) begin
    if (!rst_n) rsp <= 1'b0;
    else        rsp <= req;
  end

  a_r3_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> rsp);
  a_r3_no_rsp_without_req: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> !rsp);
endmodule

// File: rtl/qpram_quad.sv
module qpram_quad
  import qpram_pkg::*;
#(
  parameter int ADDR_W = QP_ADDR_W,
  parameter int LANE_W = QP_LANE_W,
  parameter int LANES  = QP_LANES,
  localparam int WORD_W = LANE_W * LANES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arb_mode,
  input  logic              wa_valid,
  input  logic [ADDR_W-1:0] wa_addr,
  input  logic [LANES-1:0]  wa_lane_en,
  input  logic [WORD_W-1:0] wa_data,
  input  logic              wb_valid,
  input  logic [ADDR_W-1:0] wb_addr,
  input  logic [LANES-1:0]  wb_lane_en,
  input  logic [WORD_W-1:0] wb_data,
  output logic              wb_collide,
  input  logic              ra_valid,
  input  logic [ADDR_W-1:0] ra_addr,
  output logic              ra_rvalid,
  output logic [WORD_W-1:0] ra_rdata,
  input  logic              rb_valid,
  input  logic [ADDR_W-1:0] rb_addr,
  output logic              rb_rvalid,
  output logic [WORD_W-1:0] rb_rdata
);
  arb_mode_e        mode;
  logic [LANES-1:0] a_we, b_we;
  logic             clash;

  assign mode = arb_mode_e'(arb_mode);

  qpram_wr_resolve #(.ADDR_W(ADDR_W), .LANES(LANES)) u_resolve (
    .mode    (mode),
    .a_valid (wa_valid),
    .a_addr  (wa_addr),
    .a_lanes (wa_lane_en),
    .b_valid (wb_valid),
    .b_addr  (wb_addr),
    .b_lanes (wb_lane_en),
    .a_we    (a_we),
    .b_we    (b_we),
    .clash   (clash)
  );

  qpram_store #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .a_we   (a_we),
    .a_addr (wa_addr),
    .a_data (wa_data),
    .b_we   (b_we),
    .b_addr (wb_addr),
    .b_data (wb_data),
    .x_en   (ra_valid),
    .x_addr (ra_addr),
    .x_q    (ra_rdata),
    .y_en   (rb_valid),
    .y_addr (rb_addr),
    .y_q    (rb_rdata)
  );

  qpram_rd_port u_rd_a (.clk(clk), .rst_n(rst_n), .req(ra_valid), .rsp(ra_rvalid));
  qpram_rd_port u_rd_b (.clk(clk), .rst_n(rst_n), .req(rb_valid), .rsp(rb_rvalid));

  always_ff @(posedge clk) begin
    if (!rst_n) wb_collide <= 1'b0;
    else        wb_collide <= clash;
  end

  // R1: control outputs quiet right after reset release
  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!wb_collide && !ra_rvalid && !rb_rvalid));
  // R5: overlapping same-word writes under priority raise the pulse
  a_r5_flag_on_clash: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_mode && wa_valid && wb_valid && (wa_addr == wb_addr) && |(wa_lane_en & wb_lane_en))
      |=> wb_collide);
  // R6: lane-wise mode never raises the pulse
  a_r6_no_flag_lanewise: assert property (@(posedge clk) disable iff (!rst_n)
    !arb_mode |=> !wb_collide);
  // R7: disjoint lanes never raise the pulse
  a_r7_no_flag_disjoint: assert property (@(posedge clk) disable iff (!rst_n)
    ((wa_lane_en & wb_lane_en) == '0) |=> !wb_collide);
endmodule

// File: tb/qpram_quad_tb.sv
module qpram_quad_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        arb_mode = 1'b0;
  logic        wa_valid = 1'b0, wb_valid = 1'b0, ra_valid = 1'b0, rb_valid = 1'b0;
  logic [8:0]  wa_addr = '0, wb_addr = '0, ra_addr = '0, rb_addr = '0;
  logic [1:0]  wa_lane_en = '0, wb_lane_en = '0;
  logic [17:0] wa_data = '0, wb_data = '0;
  logic        wb_collide, ra_rvalid, rb_rvalid;
  logic [17:0] ra_rdata, rb_rdata;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [17:0] mdl [512];
  logic [17:0] qa_d[$];
  string       qa_t[$];
  logic [17:0] qb_d[$];
  string       qb_t[$];
  logic        qc_d[$];
  string       qc_t[$];

  always #2 clk = ~clk;

  qpram_quad u_dut (
    .clk(clk), .rst_n(rst_n), .arb_mode(arb_mode),
    .wa_valid(wa_valid), .wa_addr(wa_addr), .wa_lane_en(wa_lane_en), .wa_data(wa_data),
    .wb_valid(wb_valid), .wb_addr(wb_addr), .wb_lane_en(wb_lane_en), .wb_data(wb_data),
    .wb_collide(wb_collide),
    .ra_valid(ra_valid), .ra_addr(ra_addr), .ra_rvalid(ra_rvalid), .ra_rdata(ra_rdata),
    .rb_valid(rb_valid), .rb_addr(rb_addr), .rb_rvalid(rb_rvalid), .rb_rdata(rb_rdata)
  );

  task automatic chk(input string tag, input logic [17:0] act, input logic [17:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Driver: one cycle of stimulus, expectations pushed from the reference array
  task automatic step(input logic av, input logic [8:0] aa, input logic [1:0] al, input logic [17:0] ad,
                      input logic bv, input logic [8:0] ba, input logic [1:0] bl, input logic [17:0] bd,
                      input logic rav, input logic [8:0] raa, input logic rbv, input logic [8:0] rba,
                      input string tag);
    logic hit;
    @(negedge clk);
    wa_valid = av; wa_addr = aa; wa_lane_en = al; wa_data = ad;
    wb_valid = bv; wb_addr = ba; wb_lane_en = bl; wb_data = bd;
    ra_valid = rav; ra_addr = raa; rb_valid = rbv; rb_addr = rba;
    if (rav) begin qa_d.push_back(mdl[raa]); qa_t.push_back(tag); end
    if (rbv) begin qb_d.push_back(mdl[rba]); qb_t.push_back(tag); end
    hit = arb_mode && av && bv && (aa == ba) && |(al & bl);
    qc_d.push_back(hit); qc_t.push_back(tag);
    for (int l = 0; l < 2; l++) begin
      if (av && al[l]) mdl[aa][l*9 +: 9] = ad[l*9 +: 9];
    end
    for (int l = 0; l < 2; l++) begin
      if (bv && !hit && bl[l]) mdl[ba][l*9 +: 9] = bd[l*9 +: 9];
    end
  endtask

  task automatic rd(input logic [8:0] a, input logic [8:0] b, input string tag);
    step(0, 0, 2'b00, 0, 0, 0, 2'b00, 0, 1, a, 1, b, tag);
  endtask

  task automatic idle();
    step(0, 0, 2'b00, 0, 0, 0, 2'b00, 0, 0, 0, 0, 0, "idle");
  endtask

  // Monitor: compare outputs 1 ns after each edge against popped expectations
  always @(posedge clk) begin
    #1;
    if (rst_n) begin
      if (qc_d.size() != 0) begin
        chk({qc_t.pop_front(), " collide"}, {17'd0, wb_collide}, {17'd0, qc_d.pop_front()});
      end
      if (qa_d.size() != 0) begin
        chk({qa_t[0], " ra_rvalid R3"}, {17'd0, ra_rvalid}, 18'd1);
        chk({qa_t.pop_front(), " ra_rdata"}, ra_rdata, qa_d.pop_front());
      end else if (ra_rvalid) chk("R3 unexpected ra_rvalid", 18'd1, 18'd0);
      if (qb_d.size() != 0) begin
        chk({qb_t[0], " rb_rvalid R3"}, {17'd0, rb_rvalid}, 18'd1);
        chk({qb_t.pop_front(), " rb_rdata"}, rb_rdata, qb_d.pop_front());
      end else if (rb_rvalid) chk("R3 unexpected rb_rvalid", 18'd1, 18'd0);
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R3 watchdog actual=hung expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset ra_rvalid", {17'd0, ra_rvalid}, 18'd0);
    chk("R1 reset rb_rvalid", {17'd0, rb_rvalid}, 18'd0);
    chk("R1 reset collide", {17'd0, wb_collide}, 18'd0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1 post-reset ra_rvalid", {17'd0, ra_rvalid}, 18'd0);
    chk("R1 post-reset collide", {17'd0, wb_collide}, 18'd0);

    // R8: both ports fill different words in the same cycle
    for (int i = 0; i < 12; i++)
      step(1, 9'(i), 2'b11, 18'h01000 + 18'(i * 37), 1, 9'(256 + i), 2'b11, 18'h2A000 + 18'(i * 5),
           0, 0, 0, 0, "R8 fill");
    for (int i = 0; i < 12; i++) rd(9'(i), 9'(256 + i), "R8 R3 readback");

    // R2: single-lane writes
    step(1, 3, 2'b01, 18'h3FFFF, 1, 257, 2'b10, 18'h15555, 0, 0, 0, 0, "R2 lane write");
    rd(3, 257, "R2 lane mask");

    // R9: no valid, or no lanes
    step(0, 4, 2'b11, 18'h3FFFF, 1, 258, 2'b00, 18'h3FFFF, 0, 0, 0, 0, "R9 void write");
    rd(4, 258, "R9 unchanged");

    // R4: read-during-write returns old word
    step(1, 5, 2'b11, 18'h0BEEF, 0, 0, 2'b00, 0, 1, 5, 1, 5, "R4 old data");
    rd(5, 5, "R4 new data");

    // R5: priority mode clashes
    arb_mode = 1'b1;
    step(1, 6, 2'b11, 18'h11111, 1, 6, 2'b11, 18'h22222, 0, 0, 0, 0, "R5 full clash");
    step(1, 7, 2'b01, 18'h00123, 1, 7, 2'b11, 18'h3FEDC, 0, 0, 0, 0, "R5 partial clash");
    step(1, 7, 2'b10, 18'h2AA00, 1, 7, 2'b10, 18'h15400, 0, 0, 0, 0, "R5 back-to-back clash");
    rd(6, 7, "R5 A wins");

    // R6: lane-wise mode clash
    arb_mode = 1'b0;
    step(1, 8, 2'b11, 18'h0AAAA, 1, 8, 2'b10, 18'h35555, 0, 0, 0, 0, "R6 lanewise");
    step(1, 9, 2'b01, 18'h00077, 1, 9, 2'b11, 18'h3CCCC, 0, 0, 0, 0, "R6 B covers all");
    rd(8, 9, "R6 result");

    // R7: disjoint lanes merge in both modes
    step(1, 10, 2'b01, 18'h000AB, 1, 10, 2'b10, 18'h3FE00, 0, 0, 0, 0, "R7 merge lanewise");
    arb_mode = 1'b1;
    step(1, 11, 2'b10, 18'h24600, 1, 11, 2'b01, 18'h000CD, 0, 0, 0, 0, "R7 merge priority");
    rd(10, 11, "R7 merged");
    arb_mode = 1'b0;

    idle(); idle(); idle();
    @(negedge clk);
    chk("R3 no pending reads", 18'(qa_d.size() + qb_d.size()), 18'd0);
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule